// File: doc/BRIEF.md
# Skip-Branch and Call-Stack Sequencer

This block is the program-flow unit of a small 8-bit machine. It owns the 16-bit program counter and the stack pointer. Each cycle it takes one decoded flow opcode and updates both. It performs absolute jumps and compare-and-skip tests on two 8-bit operands. It also handles subroutine linkage: loading the stack pointer, call, return, push and pop.

A conditional test never jumps by itself. If the relation holds, execution falls through to the next instruction. If it fails, the next instruction is skipped. Branching to an arbitrary address therefore takes a test followed by a jump. A call stores the return address on the stack as two bytes. A return first pops an argument count N, throws away N entries, and then pops the two return-address bytes.

The stack memory is external. It is reached through a single byte-wide port that does one access per cycle and has a combinational read path. Call and return use that port more than once, so they last several cycles. During that time `busy_o` tells instruction fetch to keep the same opcode on the inputs.

Top module: `pcflow_unit`

## Requirements
- R1: While `rst_n` is low at a clock edge, PC and SP become 0, and in the following cycle no stack access and no busy are signalled for a NOP opcode.
- R2: NOP (code 0) and any code from 13 to 15 advance the PC by 1 and leave the SP unchanged.
- R3: JMP (code 1) loads `addr_i` into the PC in one cycle.
- R4: The compare opcodes use these codes: 2 equal, 3 not equal, 4 less-or-equal, 5 greater-or-equal, 6 less, 7 greater. They compare the two operands as unsigned 8-bit values. The PC advances by 1 when the relation holds and by 2 when it fails.
- R5: `imm_sel_i[1]` set takes the left operand from `lhs_imm_i` instead of `lhs_reg_i`. `imm_sel_i[0]` set takes the right operand from `rhs_imm_i` instead of `rhs_reg_i`.
- R6: SETSP (code 8) loads `addr_i` into the SP and advances the PC by 1.
- R7: PUSH (code 11) writes the left operand to stack address SP, increments the SP, and advances the PC by 1.
- R8: POP (code 12) reads stack address SP-1 in the same cycle. It raises `pop_we_o` with the byte read on `pop_data_o`, decrements the SP, and advances the PC by 1.
- R9: CALL (code 9) takes 2 cycles, with `busy_o` high in the first. It writes the high byte of PC+1 at SP and then the low byte at SP+1. The SP ends 2 higher, and the PC holds until it loads `addr_i` at the second edge.
- R10: RET (code 10) takes 3 cycles, with `busy_o` high in the first two. It pops a count N and lowers the SP by N more. It then pops the low byte and then the high byte of the return address. The PC holds until it loads that address at the third edge.
- R11: While `halt_i` is high, PC, SP and the sequence phase do not change, and no stack access or pop write is issued.
- R12: A stack read and a stack write are never requested in the same cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| halt_i | input | 1 | Freeze PC, SP and sequencing |
| op_i | input | 4 | Decoded flow opcode |
| imm_sel_i | input | 2 | Bit 1: left operand from immediate; bit 0: right operand from immediate |
| lhs_reg_i | input | 8 | Left operand from register file |
| lhs_imm_i | input | 8 | Left operand immediate |
| rhs_reg_i | input | 8 | Right operand from register file |
| rhs_imm_i | input | 8 | Right operand immediate |
| addr_i | input | 16 | Address field of the instruction |
| stk_rdata_i | input | 8 | Stack memory read data (combinational) |
| pc_o | output | 16 | Program counter |
| sp_o | output | 16 | Stack pointer |
| busy_o | output | 1 | Multi-cycle sequence in progress; hold the opcode |
| stk_we_o | output | 1 | Stack write strobe |
| stk_re_o | output | 1 | Stack read strobe |
| stk_addr_o | output | 16 | Stack memory address |
| stk_wdata_o | output | 8 | Stack write data |
| pop_we_o | output | 1 | Destination register write strobe for POP |
| pop_data_o | output | 8 | Byte popped for the destination register |

## Verification
Stack strobes, the write byte and the pop data depend combinationally on the inputs. They are sampled on the falling edge after the opcode is driven, in the same cycle as the request. PC and SP are registered. For single-cycle opcodes they are checked one edge after the opcode is applied. For CALL and RET they are checked after the second and third edge. The PC is also checked after each intermediate edge to confirm that it holds. The bench model keeps its own byte array for the stack, so a return address or argument count written wrongly by the design shows up as a wrong PC or SP.

// File: rtl/pcflow_pkg.sv
// Shared opcode encoding and sizes for the program-flow unit.
package pcflow_pkg;

    // Flow opcodes; codes 13..15 behave as ordinary (non-flow) instructions.
    typedef enum logic [3:0] {
        OP_NOP   = 4'd0,
        OP_JMP   = 4'd1,
        OP_SKEQ  = 4'd2,
        OP_SKNE  = 4'd3,
        OP_SKLE  = 4'd4,
        OP_SKGE  = 4'd5,
        OP_SKLT  = 4'd6,
        OP_SKGT  = 4'd7,
        OP_SETSP = 4'd8,
        OP_CALL  = 4'd9,
        OP_RET   = 4'd10,
        OP_PUSH  = 4'd11,
        OP_POP   = 4'd12
    } flow_op_e;

    localparam int OP_W = 4;

endpackage

// File: rtl/pcflow_cmp.sv
// Operand selection and relation test for the skip opcodes.
// Assumes: operands are DATA_W wide; SIGNED_CMP picks two's-complement
// comparison, default unsigned. Purely combinational.
module pcflow_cmp
    import pcflow_pkg::*;
#(
    parameter int DATA_W     = 8,
    parameter bit SIGNED_CMP = 1'b0
) (
    input  flow_op_e            op_i,
    input  logic [1:0]          imm_sel_i,
    input  logic [DATA_W-1:0]   lhs_reg_i,
    input  logic [DATA_W-1:0]   lhs_imm_i,
    input  logic [DATA_W-1:0]   rhs_reg_i,
    input  logic [DATA_W-1:0]   rhs_imm_i,
    output logic [DATA_W-1:0]   lhs_val_o,
    output logic                is_skip_o,
    output logic                holds_o
);

    logic [DATA_W-1:0] rhs_val;
    logic              lt, eq;

    // Pick each operand from register or immediate.
    always_comb begin
        lhs_val_o = imm_sel_i[1] ? lhs_imm_i : lhs_reg_i;
        rhs_val   = imm_sel_i[0] ? rhs_imm_i : rhs_reg_i;
    end

    assign eq = (lhs_val_o == rhs_val);

    // Parameter chooses the ordering used by less-than.
    generate
        if (SIGNED_CMP) begin : g_signed
            assign lt = $signed(lhs_val_o) < $signed(rhs_val);
        end else begin : g_unsigned
            assign lt = lhs_val_o < rhs_val;
        end
    endgenerate

    // Evaluate the relation named by the opcode.
    always_comb begin
        is_skip_o = 1'b1;
        holds_o   = 1'b0;
        unique case (op_i)
            OP_SKEQ: holds_o = eq;
            OP_SKNE: holds_o = !eq;
            OP_SKLE: holds_o = lt || eq;
            OP_SKGE: holds_o = !lt;
            OP_SKLT: holds_o = lt;
            OP_SKGT: holds_o = !lt && !eq;
            default: is_skip_o = 1'b0;
        endcase
    end

endmodule

// File: rtl/pcflow_stack.sv
// Stack pointer, multi-cycle phase counter and stack memory requests.
// Assumes: upward stack (write at SP then SP+1; pop from SP-1), one
// memory access per cycle with combinational read data, and an address
// that is a whole number of DATA_W chunks, stored high chunk first.
module pcflow_stack
    import pcflow_pkg::*;
#(
    parameter int ADDR_W = 16,
    parameter int DATA_W = 8
) (
    input  logic                clk,
    input  logic                rst_n,
    input  logic                halt_i,
    input  flow_op_e            op_i,
    input  logic [DATA_W-1:0]   lhs_val_i,
    input  logic [ADDR_W-1:0]   addr_i,
    input  logic [ADDR_W-1:0]   link_i,
    input  logic [DATA_W-1:0]   stk_rdata_i,
    output logic [ADDR_W-1:0]   sp_o,
    output logic                busy_o,
    output logic                call_done_o,
    output logic                ret_done_o,
    output logic [ADDR_W-1:0]   ret_addr_o,
    output logic                stk_we_o,
    output logic                stk_re_o,
    output logic [ADDR_W-1:0]   stk_addr_o,
    output logic [DATA_W-1:0]   stk_wdata_o,
    output logic                pop_we_o,
    output logic [DATA_W-1:0]   pop_data_o
);

    localparam int CHUNKS = ADDR_W / DATA_W;
    localparam int PH_W   = $clog2(CHUNKS + 1);

    logic [ADDR_W-1:0] sp_q, sp_n;
    logic [PH_W-1:0]   ph_q, ph_n;
    logic [ADDR_W-1:0] ret_buf_q;
    logic [ADDR_W-1:0] sp_dec;
    int                ph_int;

    assign sp_dec = sp_q - ADDR_W'(1);
    assign ph_int = int'(ph_q);

    // Next SP, next phase and the memory request for this cycle.
    always_comb begin
        sp_n        = sp_q;
        ph_n        = '0;
        busy_o      = 1'b0;
        call_done_o = 1'b0;
        ret_done_o  = 1'b0;
        stk_we_o    = 1'b0;
        stk_re_o    = 1'b0;
        stk_addr_o  = sp_q;
        stk_wdata_o = '0;
        pop_we_o    = 1'b0;
        if (halt_i) begin
            ph_n = ph_q;
        end else begin
            unique case (op_i)
                OP_SETSP: sp_n = addr_i;
                OP_PUSH: begin
                    stk_we_o    = 1'b1;
                    stk_wdata_o = lhs_val_i;
                    sp_n        = sp_q + ADDR_W'(1);
                end
                OP_POP: begin
                    stk_re_o   = 1'b1;
                    stk_addr_o = sp_dec;
                    pop_we_o   = 1'b1;
                    sp_n       = sp_dec;
                end
                OP_CALL: begin
                    stk_we_o    = 1'b1;
                    stk_wdata_o = link_i[(CHUNKS-1-ph_int)*DATA_W +: DATA_W];
                    sp_n        = sp_q + ADDR_W'(1);
                    if (ph_int == CHUNKS - 1) begin
                        call_done_o = 1'b1;
                    end else begin
                        busy_o = 1'b1;
                        ph_n   = ph_q + PH_W'(1);
                    end
                end
                OP_RET: begin
                    stk_re_o   = 1'b1;
                    stk_addr_o = sp_dec;
                    if (ph_int == 0) begin
                        sp_n   = sp_dec - ADDR_W'(stk_rdata_i);
                        busy_o = 1'b1;
                        ph_n   = PH_W'(1);
                    end else begin
                        sp_n = sp_dec;
                        if (ph_int == CHUNKS) begin
                            ret_done_o = 1'b1;
                        end else begin
                            busy_o = 1'b1;
                            ph_n   = ph_q + PH_W'(1);
                        end
                    end
                end
                default: ;
            endcase
        end
    end

    // Return address: gathered chunks plus the one read this cycle.
    always_comb begin
        ret_addr_o = ret_buf_q;
        ret_addr_o[(CHUNKS-1)*DATA_W +: DATA_W] = stk_rdata_i;
    end

    assign pop_data_o = stk_rdata_i;
    assign sp_o       = sp_q;

    // SP and phase registers.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            sp_q <= '0;
            ph_q <= '0;
        end else begin
            sp_q <= sp_n;
            ph_q <= ph_n;
        end
    end

    // Collect return-address chunks popped low first.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            ret_buf_q <= '0;
        end else if (!halt_i && op_i == OP_RET && ph_int != 0) begin
            ret_buf_q[(ph_int-1)*DATA_W +: DATA_W] <= stk_rdata_i;
        end
    end

    assert_one_access_R12: assert property (@(posedge clk) disable iff (!rst_n)
        !(stk_we_o && stk_re_o));

    assert_halt_quiet_R11: assert property (@(posedge clk) disable iff (!rst_n)
        halt_i |-> (!stk_we_o && !stk_re_o && !pop_we_o));

    assert_halt_sp_R11: assert property (@(posedge clk) disable iff (!rst_n)
        halt_i |=> $stable(sp_q));

    assert_push_grow_R7: assert property (@(posedge clk) disable iff (!rst_n)
        (!halt_i && op_i == OP_PUSH) |=> (sp_q == $past(sp_q) + ADDR_W'(1)));

    assert_pop_shrink_R8: assert property (@(posedge clk) disable iff (!rst_n)
        (!halt_i && op_i == OP_POP) |=> (sp_q == $past(sp_q) - ADDR_W'(1)));

endmodule

// File: rtl/pcflow_pc.sv
// Program counter register and next-PC selection.
// Assumes: the stack unit signals when a call or return completes and
// raises busy while a sequence is still running; the PC holds meanwhile.
module pcflow_pc
    import pcflow_pkg::*;
#(
    parameter int ADDR_W = 16
) (
    input  logic                clk,
    input  logic                rst_n,
    input  logic                halt_i,
    input  flow_op_e            op_i,
    input  logic [ADDR_W-1:0]   addr_i,
    input  logic                is_skip_i,
    input  logic                holds_i,
    input  logic                busy_i,
    input  logic                call_done_i,
    input  logic                ret_done_i,
    input  logic [ADDR_W-1:0]   ret_addr_i,
    output logic [ADDR_W-1:0]   pc_o,
    output logic [ADDR_W-1:0]   link_o
);

    logic [ADDR_W-1:0] pc_q, pc_n;

    assign link_o = pc_q + ADDR_W'(1);

    // Choose the next PC from the current opcode and stack events.
    always_comb begin
        if (halt_i || busy_i) begin
            pc_n = pc_q;
        end else if (op_i == OP_JMP || call_done_i) begin
            pc_n = addr_i;
        end else if (ret_done_i) begin
            pc_n = ret_addr_i;
        end else if (is_skip_i && !holds_i) begin
            pc_n = pc_q + ADDR_W'(2);
        end else begin
            pc_n = link_o;
        end
    end

    // PC register.
    always_ff @(posedge clk) begin
        if (!rst_n) pc_q <= '0;
        else        pc_q <= pc_n;
    end

    assign pc_o = pc_q;

    assert_jmp_load_R3: assert property (@(posedge clk) disable iff (!rst_n)
        (!halt_i && op_i == OP_JMP) |=> (pc_q == $past(addr_i)));

    assert_skip_fail_R4: assert property (@(posedge clk) disable iff (!rst_n)
        (!halt_i && is_skip_i && !holds_i) |=> (pc_q == $past(pc_q) + ADDR_W'(2)));

    assert_busy_hold_R9: assert property (@(posedge clk) disable iff (!rst_n)
        busy_i |=> $stable(pc_q));

    assert_halt_pc_R11: assert property (@(posedge clk) disable iff (!rst_n)
        halt_i |=> $stable(pc_q));

endmodule

// File: rtl/pcflow_unit.sv
// Top of the program-flow unit: wires operand compare, stack control and
// the PC register. Assumes the fetch stage holds op_i and its fields
// steady while busy_o is high.
module pcflow_unit
    import pcflow_pkg::*;
#(
    parameter int ADDR_W     = 16,
    parameter int DATA_W     = 8,
    parameter bit SIGNED_CMP = 1'b0
) (
    input  logic                clk,
    input  logic                rst_n,
    input  logic                halt_i,
    input  logic [OP_W-1:0]     op_i,
    input  logic [1:0]          imm_sel_i,
    input  logic [DATA_W-1:0]   lhs_reg_i,
    input  logic [DATA_W-1:0]   lhs_imm_i,
    input  logic [DATA_W-1:0]   rhs_reg_i,
    input  logic [DATA_W-1:0]   rhs_imm_i,
    input  logic [ADDR_W-1:0]   addr_i,
    input  logic [DATA_W-1:0]   stk_rdata_i,
    output logic [ADDR_W-1:0]   pc_o,
    output logic [ADDR_W-1:0]   sp_o,
    output logic                busy_o,
    output logic                stk_we_o,
    output logic                stk_re_o,
    output logic [ADDR_W-1:0]   stk_addr_o,
    output logic [DATA_W-1:0]   stk_wdata_o,
    output logic                pop_we_o,
    output logic [DATA_W-1:0]   pop_data_o
);

    flow_op_e          op;
    logic [DATA_W-1:0] lhs_val;
    logic              is_skip, holds;
    logic              call_done, ret_done;
    logic [ADDR_W-1:0] ret_addr, link;

    assign op = flow_op_e'(op_i);

    pcflow_cmp #(.DATA_W(DATA_W), .SIGNED_CMP(SIGNED_CMP)) u_cmp (
        .op_i      (op),
        .imm_sel_i (imm_sel_i),
        .lhs_reg_i (lhs_reg_i),
        .lhs_imm_i (lhs_imm_i),
        .rhs_reg_i (rhs_reg_i),
        .rhs_imm_i (rhs_imm_i),
        .lhs_val_o (lhs_val),
        .is_skip_o (is_skip),
        .holds_o   (holds)
    );

    pcflow_stack #(.ADDR_W(ADDR_W), .DATA_W(DATA_W)) u_stack (
        .clk         (clk),
        .rst_n       (rst_n),
        .halt_i      (halt_i),
        .op_i        (op),
        .lhs_val_i   (lhs_val),
        .addr_i      (addr_i),
        .link_i      (link),
        .stk_rdata_i (stk_rdata_i),
        .sp_o        (sp_o),
        .busy_o      (busy_o),
        .call_done_o (call_done),
        .ret_done_o  (ret_done),
        .ret_addr_o  (ret_addr),
        .stk_we_o    (stk_we_o),
        .stk_re_o    (stk_re_o),
        .stk_addr_o  (stk_addr_o),
        .stk_wdata_o (stk_wdata_o),
        .pop_we_o    (pop_we_o),
        .pop_data_o  (pop_data_o)
    );

    pcflow_pc #(.ADDR_W(ADDR_W)) u_pc (
        .clk         (clk),
        .rst_n       (rst_n),
        .halt_i      (halt_i),
        .op_i        (op),
        .addr_i      (addr_i),
        .is_skip_i   (is_skip),
        .holds_i     (holds),
        .busy_i      (busy_o),
        .call_done_i (call_done),
        .ret_done_i  (ret_done),
        .ret_addr_i  (ret_addr),
        .pc_o        (pc_o),
        .link_o      (link)
    );

endmodule

// File: tb/pcflow_unit_tb.sv
module pcflow_unit_tb;

    logic        clk = 1'b0;
    logic        rst_n;
    logic        halt_i;
    logic [3:0]  op_i;
    logic [1:0]  imm_sel_i;
    logic [7:0]  lhs_reg_i, lhs_imm_i, rhs_reg_i, rhs_imm_i;
    logic [15:0] addr_i;
    logic [7:0]  stk_rdata_i;
    logic [15:0] pc_o, sp_o, stk_addr_o;
    logic        busy_o, stk_we_o, stk_re_o, pop_we_o;
    logic [7:0]  stk_wdata_o, pop_data_o;

    int checks = 0;
    int fails  = 0;
    bit done   = 0;

    logic [7:0]  tb_mem [256];   // memory the DUT talks to
    logic [7:0]  m_mem  [256];   // model's own copy
    logic [15:0] m_pc, m_sp;

    always #5 clk = ~clk;

    pcflow_unit u_dut (
        .clk(clk), .rst_n(rst_n), .halt_i(halt_i), .op_i(op_i),
        .imm_sel_i(imm_sel_i), .lhs_reg_i(lhs_reg_i), .lhs_imm_i(lhs_imm_i),
        .rhs_reg_i(rhs_reg_i), .rhs_imm_i(rhs_imm_i), .addr_i(addr_i),
        .stk_rdata_i(stk_rdata_i), .pc_o(pc_o), .sp_o(sp_o), .busy_o(busy_o),
        .stk_we_o(stk_we_o), .stk_re_o(stk_re_o), .stk_addr_o(stk_addr_o),
        .stk_wdata_o(stk_wdata_o), .pop_we_o(pop_we_o), .pop_data_o(pop_data_o)
    );

    assign stk_rdata_i = tb_mem[stk_addr_o[7:0]];

    always @(posedge clk) if (stk_we_o) tb_mem[stk_addr_o[7:0]] <= stk_wdata_o;

    task automatic chk(input string req, input int act, input int exp);
        checks++;
        if (act != exp) begin
            fails++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    // Drive one instruction, model it, and compare every cycle.
    task automatic run(input string req, input logic [3:0] opc, input logic [1:0] sel,
                       input logic [7:0] lr, input logic [7:0] li,
                       input logic [7:0] rr, input logic [7:0] ri,
                       input logic [15:0] ad, input logic hlt);
        int          ncyc = 1;
        logic [7:0]  lv, rv, n, lo, hi, exp_pop = 8'h00;
        logic [15:0] exp_pc, exp_sp, s, link;
        bit          ok = 0;
        lv = sel[1] ? li : lr;
        rv = sel[0] ? ri : rr;
        exp_pc = m_pc + 16'd1;
        exp_sp = m_sp;
        link   = m_pc + 16'd1;
        if (hlt) exp_pc = m_pc;
        else case (opc)
            4'd1: exp_pc = ad;
            4'd2, 4'd3, 4'd4, 4'd5, 4'd6, 4'd7: begin
                case (opc)
                    4'd2: ok = (lv == rv);
                    4'd3: ok = (lv != rv);
                    4'd4: ok = (lv <= rv);
                    4'd5: ok = (lv >= rv);
                    4'd6: ok = (lv <  rv);
                    default: ok = (lv > rv);
                endcase
                exp_pc = ok ? m_pc + 16'd1 : m_pc + 16'd2;
            end
            4'd8: exp_sp = ad;
            4'd9: begin
                ncyc = 2;
                m_mem[m_sp[7:0]] = link[15:8];
                s = m_sp + 16'd1;
                m_mem[s[7:0]] = link[7:0];
                exp_sp = m_sp + 16'd2;
                exp_pc = ad;
            end
            4'd10: begin
                ncyc = 3;
                s = m_sp - 16'd1;
                n = m_mem[s[7:0]];
                s = s - {8'd0, n} - 16'd1;
                lo = m_mem[s[7:0]];
                s = s - 16'd1;
                hi = m_mem[s[7:0]];
                exp_sp = s;
                exp_pc = {hi, lo};
            end
            4'd11: begin
                m_mem[m_sp[7:0]] = lv;
                exp_sp = m_sp + 16'd1;
            end
            4'd12: begin
                exp_sp = m_sp - 16'd1;
                exp_pop = m_mem[exp_sp[7:0]];
            end
            default: ;
        endcase
        op_i = opc; imm_sel_i = sel; lhs_reg_i = lr; lhs_imm_i = li;
        rhs_reg_i = rr; rhs_imm_i = ri; addr_i = ad; halt_i = hlt;
        for (int k = 0; k < ncyc; k++) begin
            #1;
            chk({req, " busy"}, int'(busy_o), int'(k < ncyc - 1));
            chk("R12 single access", int'(stk_we_o && stk_re_o), 0);
            if (hlt) chk("R11 no access while halted",
                         int'(stk_we_o || stk_re_o || pop_we_o), 0);
            if (opc == 4'd12 && !hlt) begin
                chk("R8 pop strobe", int'(pop_we_o), 1);
                chk("R8 pop data", int'(pop_data_o), int'(exp_pop));
            end
            @(posedge clk);
            @(negedge clk);
            if (k < ncyc - 1) chk({req, " pc holds"}, int'(pc_o), int'(m_pc));
        end
        chk({req, " pc"}, int'(pc_o), int'(exp_pc));
        chk({req, " sp"}, int'(sp_o), int'(exp_sp));
        m_pc = exp_pc;
        m_sp = exp_sp;
        halt_i = 1'b0;
    endtask

    initial begin
        for (int i = 0; i < 256; i++) begin
            tb_mem[i] = 8'h00;
            m_mem[i]  = 8'h00;
        end
        rst_n = 1'b0; halt_i = 1'b0; op_i = 4'd0; imm_sel_i = 2'b00;
        lhs_reg_i = 0; lhs_imm_i = 0; rhs_reg_i = 0; rhs_imm_i = 0; addr_i = 0;
        repeat (3) @(posedge clk);
        @(negedge clk);
        rst_n = 1'b1;
        #1;
        chk("R1 pc reset", int'(pc_o), 0);
        chk("R1 sp reset", int'(sp_o), 0);
        chk("R1 quiet", int'(busy_o || stk_we_o || stk_re_o), 0);
        m_pc = 16'd0; m_sp = 16'd0;

        run("R2 nop",    4'd0,  2'b00, 0, 0, 0, 0, 16'h0000, 0);
        run("R2 nop",    4'd0,  2'b00, 0, 0, 0, 0, 16'h5555, 0);
        run("R2 code14", 4'd14, 2'b00, 0, 0, 0, 0, 16'h0000, 0);
        run("R3 jmp",    4'd1,  2'b00, 0, 0, 0, 0, 16'h1234, 0);
        run("R6 setsp",  4'd8,  2'b00, 0, 0, 0, 0, 16'h0040, 0);

        run("R4 eq hold", 4'd2, 2'b00, 8'h05, 0, 8'h05, 0, 0, 0);
        run("R4 eq fail", 4'd2, 2'b00, 8'h05, 0, 8'h06, 0, 0, 0);
        run("R4 ne hold", 4'd3, 2'b00, 8'h05, 0, 8'h06, 0, 0, 0);
        run("R4 ne fail", 4'd3, 2'b00, 8'h07, 0, 8'h07, 0, 0, 0);
        run("R4 le eq",   4'd4, 2'b00, 8'h03, 0, 8'h03, 0, 0, 0);
        run("R4 le fail", 4'd4, 2'b00, 8'h09, 0, 8'h03, 0, 0, 0);
        run("R4 ge fail", 4'd5, 2'b00, 8'h03, 0, 8'h09, 0, 0, 0);
        run("R4 ge eq",   4'd5, 2'b00, 8'h09, 0, 8'h09, 0, 0, 0);
        run("R4 lt uns",  4'd6, 2'b00, 8'h01, 0, 8'hFF, 0, 0, 0);
        run("R4 lt fail", 4'd6, 2'b00, 8'hFF, 0, 8'h01, 0, 0, 0);
        run("R4 gt uns",  4'd7, 2'b00, 8'hFF, 0, 8'h01, 0, 0, 0);
        run("R4 gt fail", 4'd7, 2'b00, 8'h01, 0, 8'h01, 0, 0, 0);

        run("R5 lhs imm",  4'd2, 2'b10, 8'h01, 8'h09, 8'h09, 8'h00, 0, 0);
        run("R5 rhs imm",  4'd2, 2'b01, 8'h04, 8'h00, 8'h00, 8'h04, 0, 0);
        run("R5 both imm", 4'd2, 2'b11, 8'h00, 8'h07, 8'h01, 8'h07, 0, 0);
        run("R5 both reg", 4'd2, 2'b00, 8'h00, 8'h07, 8'h01, 8'h07, 0, 0);

        run("R7 push reg", 4'd11, 2'b00, 8'hA5, 8'h00, 0, 0, 0, 0);
        run("R7 push imm", 4'd11, 2'b10, 8'h00, 8'h3C, 0, 0, 0, 0);
        run("R8 pop",      4'd12, 2'b00, 0, 0, 0, 0, 0, 0);
        run("R8 pop",      4'd12, 2'b00, 0, 0, 0, 0, 0, 0);

        run("R9 call",     4'd9,  2'b00, 0, 0, 0, 0, 16'h0300, 0);
        run("R7 arg",      4'd11, 2'b00, 8'h11, 0, 0, 0, 0, 0);
        run("R7 arg",      4'd11, 2'b00, 8'h22, 0, 0, 0, 0, 0);
        run("R7 count",    4'd11, 2'b10, 0, 8'h02, 0, 0, 0, 0);
        run("R10 ret",     4'd10, 2'b00, 0, 0, 0, 0, 0, 0);
        run("R9 call",     4'd9,  2'b00, 0, 0, 0, 0, 16'hABCD, 0);
        run("R7 zero cnt", 4'd11, 2'b10, 0, 8'h00, 0, 0, 0, 0);
        run("R10 ret n0",  4'd10, 2'b00, 0, 0, 0, 0, 0, 0);

        run("R11 halt jmp",  4'd1,  2'b00, 0, 0, 0, 0, 16'hBEEF, 1);
        run("R11 halt push", 4'd11, 2'b00, 8'h77, 0, 0, 0, 0, 1);
        run("R11 halt call", 4'd9,  2'b00, 0, 0, 0, 0, 16'h0999, 1);
        run("R8 pop after halt", 4'd12, 2'b00, 0, 0, 0, 0, 0, 0);
        run("R2 nop",        4'd0,  2'b00, 0, 0, 0, 0, 0, 0);

        if (!done) begin
            done = 1;
            $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
            $finish;
        end
    end

    initial begin
        repeat (20000) @(posedge clk);
        if (!done) begin
            done = 1;
            checks++;
            fails++;
            $display("FAIL watchdog expired actual=running expected=finished");
            $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
            $finish;
        end
    end

endmodule